// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block is the transmit side of a small Ethernet controller as software sees it through registers. It holds four descriptor slots. Each slot has a 32-bit buffer address register and a 32-bit status/command register. A host write to a slot's status register hands that slot to the engine. The engine reads the frame from a byte-wide memory request/response port and streams it out of a byte-wide transmit port. When the frame is done, it writes completion status back into the slot, sets that slot's bit in a summary register and raises an interrupt flag.

The host fills the slots in strict rotation (0, 1, 2, 3, 0, ...). The engine serves them in the same order, one whole frame at a time. Frames shorter than 60 bytes are padded with zero bytes up to 60.

Both data interfaces use valid/ready handshakes:
- **Memory request:** `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen. At most one request is outstanding.
- **Memory response:** there is no ready signal. The engine accepts `mem_rsp_valid` in any cycle in which it waits for data.
- **Transmit port:** `tx_data` and `tx_last` stay stable while `tx_valid` is high and `tx_ready` is low.

MAC framing, CRC and the PHY are not part of this block.

Top module: `txd_engine`

## Requirements
- R1: After reset every slot status word reads 0x00002000 (host owns the slot), the summary register (offset 0x60) and the interrupt status register (offset 0x3C) read 0, `irq` is low, and neither `tx_valid` nor `mem_req_valid` is asserted.
- R2: A handed-over frame of length L ≥ 60 leaves the transmit port as exactly L bytes. Byte i is the memory byte at buffer address + i. `tx_last` is high on the final byte only.
- R3: A frame with length L < 60 (including 0) is sent as 60 bytes: the L memory bytes followed by zero bytes, with `tx_last` on byte 59.
- R4: Slot n has its status register at 0x10+4n. Writing it stores the length field (bits 12:0) and the threshold field (bits 21:16), and reads back as the written word ANDed with 0x003F1FFF. This clears the ownership bit 13, the underrun bit 14, the completion bit 15 and error bits 31:29, and it clears summary bit n.
- R5: When a frame's last byte is accepted, that slot's status gains bit 13 and bit 15. Summary bit n (bits 3:0 at 0x60) is set, and interrupt status bit 2 (0x04) is set.
- R6: An error response from memory ends the frame without sending further bytes. The slot's status gains bit 13 and the aborted bit 30 but not bit 15. The summary bit is set, and interrupt status bit 3 (0x08) is set.
- R7: Interrupt status bits 2 and 3 are cleared by writing 1 to them at offset 0x3C; a 0 written leaves a bit unchanged. `irq` is high exactly when either bit is set.
- R8: A write to the status register of a slot that is still pending or in flight is ignored: no status change and no extra frame.
- R9: The engine serves slots in index order. A slot handed over out of turn waits, with no memory request or transmit activity, until the slots before it have been handed over and sent.
- R10: Only one frame is in progress at a time. No memory request is issued while a byte is being offered, and after a last byte is accepted nothing is offered in the next cycle.
- R11: Under back-pressure, `mem_req_addr` and the `tx_data`/`tx_last` pair stay stable until their handshake completes.
- R12: The buffer address register of slot n (0x20+4n) reads back as written. Its value and the length are latched when the frame starts, so rewriting them mid-frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address requested |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 8 | Memory response byte |
| mem_rsp_err | input | 1 | Memory response carries an error |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | Transmit interrupt pending |

## Verification
Two situations are hardest to reach from the ports:
- **A host write that lands while the slot is still owned by the engine.** The bench writes the same slot's status and address again a few cycles after the first hand-over of a long frame. It then checks that the read-back value, the streamed bytes and the frame count are unchanged.
- **A slot handed over out of rotation.** The bench writes the next-but-one slot first, watches the ports stay idle for a window, and then writes the expected slot. It expects both frames, in index order.

Memory error responses are injected at a chosen byte offset of one frame, so that truncation and the aborted status can be seen. Random ready and latency on both data interfaces exercise the back-pressure rules.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
  localparam int unsigned STAT_BASE = 'h10;
  localparam int unsigned ADDR_BASE = 'h20;
  localparam int unsigned INTS_OFS  = 'h3C;
  localparam int unsigned SUMM_OFS  = 'h60;

  localparam int OWN_BIT   = 13;
  localparam int OK_BIT    = 15;
  localparam int ABORT_BIT = 30;

  localparam int INT_OK_BIT  = 2;
  localparam int INT_ERR_BIT = 3;

  // length bits 12:0 and threshold bits 21:16 survive a host write
  localparam logic [31:0] STAT_WR_MASK = 32'h003F_1FFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SEND
  } strm_state_e;
endpackage

// File: rtl/txd_slot_bank.sv
`timescale 1ns/1ps
module txd_slot_bank
  import txd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int LEN_W = 13,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSLOT-1:0]              wr_stat,
  input  logic [NSLOT-1:0]              wr_addr,
  input  logic [31:0]                   wdata,
  input  logic                          done_ok,
  input  logic                          done_err,
  input  logic [SW-1:0]                 done_slot,
  output logic [NSLOT-1:0][31:0]        stat,
  output logic [NSLOT-1:0][AW-1:0]      baddr,
  output logic [NSLOT-1:0][LEN_W-1:0]   slot_len,
  output logic [NSLOT-1:0]              pend,
  output logic [NSLOT-1:0]              summ
);
  logic [31:0] done_bits;

  always_comb begin
    done_bits = '0;
    done_bits[OWN_BIT] = 1'b1;
    if (done_err) done_bits[ABORT_BIT] = 1'b1;
    else          done_bits[OK_BIT]    = 1'b1;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit_done;
    assign hit_done    = (done_ok || done_err) && (done_slot == SW'(g));
    assign slot_len[g] = stat[g][LEN_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[g] <= 32'h0000_2000;
        pend[g] <= 1'b0;
        summ[g] <= 1'b0;
      end else if (hit_done) begin
        stat[g] <= stat[g] | done_bits;
        pend[g] <= 1'b0;
        summ[g] <= 1'b1;
      end else if (wr_stat[g] && !pend[g]) begin
        stat[g] <= wdata & STAT_WR_MASK;
        pend[g] <= 1'b1;
        summ[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          baddr[g] <= '0;
      else if (wr_addr[g]) baddr[g] <= wdata[AW-1:0];
    end
  end
endmodule

// File: rtl/txd_streamer.sv
`timescale 1ns/1ps
module txd_streamer
  import txd_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int AW      = 32,
  parameter int LEN_W   = 13,
  parameter int MIN_LEN = 60,
  parameter int SW      = $clog2(NSLOT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSLOT-1:0]            pend,
  input  logic [NSLOT-1:0][LEN_W-1:0] slot_len,
  input  logic [NSLOT-1:0][AW-1:0]    baddr,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [AW-1:0]               mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [7:0]                  mem_rsp_data,
  input  logic                        mem_rsp_err,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [7:0]                  tx_data,
  output logic                        tx_last,
  output logic                        done_ok,
  output logic                        done_err,
  output logic [SW-1:0]               cur_slot
);
  localparam logic [LEN_W-1:0] MINL = LEN_W'(MIN_LEN);

  strm_state_e      st;
  logic [SW-1:0]    ptr, ptr_nx;
  logic [AW-1:0]    base;
  logic [LEN_W-1:0] dlen, flen, idx;
  logic [7:0]       hold;
  logic             need_mem, last_byte;

  assign need_mem  = idx < dlen;
  assign last_byte = idx == (flen - 1'b1);
  assign ptr_nx    = (ptr == SW'(NSLOT-1)) ? '0 : ptr + 1'b1;

  assign mem_req_valid = (st == ST_FETCH) && need_mem;
  assign mem_req_addr  = base + AW'(idx);
  assign tx_valid      = (st == ST_SEND);
  assign tx_data       = hold;
  assign tx_last       = (st == ST_SEND) && last_byte;
  assign done_ok       = (st == ST_SEND) && tx_ready && last_byte;
  assign done_err      = (st == ST_WAIT) && mem_rsp_valid && mem_rsp_err;
  assign cur_slot      = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ptr  <= '0;
      base <= '0;
      dlen <= '0;
      flen <= '0;
      idx  <= '0;
      hold <= '0;
    end else begin
      case (st)
        ST_IDLE: if (pend[ptr]) begin
          base <= baddr[ptr];
          dlen <= slot_len[ptr];
          flen <= (slot_len[ptr] < MINL) ? MINL : slot_len[ptr];
          idx  <= '0;
          st   <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!need_mem) begin
            hold <= 8'h00;
            st   <= ST_SEND;
          end else if (mem_req_ready) begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            st  <= ST_IDLE;
            ptr <= ptr_nx;
          end else begin
            hold <= mem_rsp_data;
            st   <= ST_SEND;
          end
        end
        ST_SEND: if (tx_ready) begin
          if (last_byte) begin
            st  <= ST_IDLE;
            ptr <= ptr_nx;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_regs.sv
`timescale 1ns/1ps
module txd_regs
  import txd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int RAW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [RAW-1:0]           reg_addr,
  input  logic [31:0]              reg_wdata,
  input  logic [NSLOT-1:0][31:0]   stat,
  input  logic [NSLOT-1:0][AW-1:0] baddr,
  input  logic [NSLOT-1:0]         summ,
  input  logic                     done_ok,
  input  logic                     done_err,
  output logic [NSLOT-1:0]         wr_stat,
  output logic [NSLOT-1:0]         wr_addr,
  output logic [31:0]              reg_rdata,
  output logic                     int_ok,
  output logic                     int_err
);
  logic wr_int;
  assign wr_int = reg_wr && (reg_addr == RAW'(INTS_OFS));

  for (genvar g = 0; g < NSLOT; g++) begin : g_dec
    assign wr_stat[g] = reg_wr && (reg_addr == RAW'(STAT_BASE + 4 * g));
    assign wr_addr[g] = reg_wr && (reg_addr == RAW'(ADDR_BASE + 4 * g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_ok  <= 1'b0;
      int_err <= 1'b0;
    end else begin
      if (done_ok)                              int_ok <= 1'b1;
      else if (wr_int && reg_wdata[INT_OK_BIT]) int_ok <= 1'b0;
      if (done_err)                               int_err <= 1'b1;
      else if (wr_int && reg_wdata[INT_ERR_BIT])  int_err <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (reg_addr == RAW'(STAT_BASE + 4 * i)) reg_rdata = stat[i];
      if (reg_addr == RAW'(ADDR_BASE + 4 * i)) reg_rdata = 32'(baddr[i]);
    end
    if (reg_addr == RAW'(SUMM_OFS)) reg_rdata = 32'(summ);
    if (reg_addr == RAW'(INTS_OFS)) begin
      reg_rdata[INT_OK_BIT]  = int_ok;
      reg_rdata[INT_ERR_BIT] = int_err;
    end
  end
endmodule

// File: rtl/txd_engine.sv
`timescale 1ns/1ps
module txd_engine #(
  parameter int NSLOT   = 4,
  parameter int AW      = 32,
  parameter int LEN_W   = 13,
  parameter int MIN_LEN = 60,
  parameter int RAW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [7:0]     mem_rsp_data,
  input  logic           mem_rsp_err,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  output logic           irq
);
  localparam int SW = $clog2(NSLOT);

  logic [NSLOT-1:0]            wr_stat, wr_addr, pend, summ;
  logic [NSLOT-1:0][31:0]      stat;
  logic [NSLOT-1:0][AW-1:0]    baddr;
  logic [NSLOT-1:0][LEN_W-1:0] slot_len;
  logic                        done_ok, done_err, int_ok, int_err;
  logic [SW-1:0]               cur_slot;

  txd_slot_bank #(.NSLOT(NSLOT), .AW(AW), .LEN_W(LEN_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_addr(wr_addr),
    .wdata(reg_wdata), .done_ok(done_ok), .done_err(done_err),
    .done_slot(cur_slot), .stat(stat), .baddr(baddr), .slot_len(slot_len),
    .pend(pend), .summ(summ)
  );

  txd_streamer #(.NSLOT(NSLOT), .AW(AW), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_strm (
    .clk(clk), .rst_n(rst_n), .pend(pend), .slot_len(slot_len), .baddr(baddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .done_ok(done_ok), .done_err(done_err),
    .cur_slot(cur_slot)
  );

  txd_regs #(.NSLOT(NSLOT), .AW(AW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat(stat), .baddr(baddr), .summ(summ),
    .done_ok(done_ok), .done_err(done_err), .wr_stat(wr_stat),
    .wr_addr(wr_addr), .reg_rdata(reg_rdata), .int_ok(int_ok),
    .int_err(int_err)
  );

  assign irq = int_ok || int_err;
endmodule

// File: rtl/txd_checker.sv
`timescale 1ns/1ps
module txd_checker
  import txd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int RAW   = 8,
  parameter int SW    = $clog2(NSLOT)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [RAW-1:0]         reg_addr,
  input logic                   mem_req_valid,
  input logic                   mem_req_ready,
  input logic [AW-1:0]          mem_req_addr,
  input logic                   tx_valid,
  input logic                   tx_ready,
  input logic [7:0]             tx_data,
  input logic                   tx_last,
  input logic                   done_ok,
  input logic                   done_err,
  input logic [SW-1:0]          cur_slot,
  input logic [NSLOT-1:0]       pend,
  input logic [NSLOT-1:0]       summ,
  input logic [NSLOT-1:0][31:0] stat
);
  // R10: never fetch while a byte is on offer
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !tx_valid);

  // R10: idle cycle after a frame's last byte is taken
  a_r10_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (!tx_valid && !mem_req_valid));

  // R11: transmit byte stable under back-pressure
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R11: memory request stable until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9: engine activity only on a slot the host has handed over
  a_r9_active_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || tx_valid) |-> pend[cur_slot]);

  // R5: completion releases the slot and sets its summary bit
  a_r5_done_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> (summ[$past(cur_slot)] && !pend[$past(cur_slot)]));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    // R8: a status write to a busy slot changes nothing
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RAW'(STAT_BASE + 4 * g) && pend[g] &&
       !((done_ok || done_err) && cur_slot == SW'(g)))
      |=> $stable(stat[g]));
  end
endmodule

bind txd_engine txd_checker #(.NSLOT(NSLOT), .AW(AW), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .done_ok(done_ok),
  .done_err(done_err), .cur_slot(cur_slot), .pend(pend), .summ(summ),
  .stat(stat)
);

// File: tb/txd_engine_bench.sv
`timescale 1ns/1ps
module txd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        tx_valid, tx_ready = 1'b0, tx_last, irq;
  logic [7:0]  tx_data;

  txd_engine u_txd_engine (.*);

  always #5 clk = ~clk;

  int ck = 0, fl = 0;
  int unsigned seed_dummy;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  // expected frame queue, in service order
  logic [31:0] q_base[256];
  int          q_len[256], q_cnt[256];
  bit          q_err[256];
  int          qh = 0, qt = 0;

  logic [31:0] s_base[4], s_word[4];
  bit          s_err[4];
  int          nxt = 0;
  int          r10_viol = 0, r11_viol = 0;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] exp_done(input logic [31:0] w, input bit e);
    return (w & 32'h003F_1FFF) | 32'h0000_2000 | (e ? 32'h4000_0000 : 32'h0000_8000);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ck++;
    if (!ok) begin
      fl++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ck, fl);
    $finish;
  endtask

  // memory responder
  initial begin : mem_model
    bit waiting = 0;
    int cnt = 0;
    logic [31:0] raddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (waiting) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_err   = (raddr == err_addr);
          mem_rsp_data  = mem_rsp_err ? 8'($urandom) : mem_byte(raddr);
          waiting = 0;
        end else cnt--;
      end
      mem_req_ready = !waiting && (($urandom % 3) != 0);
      if (mem_req_valid && mem_req_ready) begin
        waiting = 1;
        cnt     = $urandom % 3;
        raddr   = mem_req_addr;
      end
    end
  end

  // transmit sink and frame checker
  initial begin : tx_sink
    int bidx = 0;
    bit fbad = 0, held = 0;
    logic [7:0] bad_act = '0, bad_exp = '0, hd = '0;
    logic hl = 1'b0;
    logic [7:0] eb;
    logic el;
    forever begin
      @(negedge clk);
      if (mem_req_valid && tx_valid) r10_viol++;
      if (held && tx_valid && (tx_data !== hd || tx_last !== hl)) r11_viol++;
      held = 0;
      tx_ready = (($urandom % 4) != 0);
      if (tx_valid && !tx_ready) begin
        held = 1; hd = tx_data; hl = tx_last;
      end
      if (tx_valid && tx_ready) begin
        if (qh == qt) begin
          chk(0, "R8 unexpected byte", 32'(tx_data), 32'hFFFF_FFFF);
        end else begin
          eb = (bidx < q_len[qh]) ? mem_byte(q_base[qh] + 32'(bidx)) : 8'h00;
          el = !q_err[qh] && (bidx == q_cnt[qh] - 1);
          if (!fbad && (tx_data !== eb || tx_last !== el)) begin
            fbad = 1; bad_act = tx_data; bad_exp = eb;
          end
          bidx++;
          if (bidx == q_cnt[qh]) begin
            if (q_err[qh])          chk(!fbad, "R6 truncated frame bytes", 32'(bad_act), 32'(bad_exp));
            else if (q_len[qh] < 60) chk(!fbad, "R3 padded frame bytes", 32'(bad_act), 32'(bad_exp));
            else                     chk(!fbad, "R2 frame bytes/last", 32'(bad_act), 32'(bad_exp));
            qh++; bidx = 0; fbad = 0;
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic prep(input int s, input int len, input int errk);
    int c;
    s_base[s] = ($urandom & 32'h00FF_F000) | 32'h0000_0100;
    s_word[s] = ($urandom & 32'hFFFF_E000) | 32'(len);
    s_err[s]  = (errk >= 0);
    if (errk >= 0) begin
      err_addr = s_base[s] + 32'(errk);
      c = errk;
    end else c = (len < 60) ? 60 : len;
    if (c > 0) begin
      q_base[qt] = s_base[s]; q_len[qt] = len; q_cnt[qt] = c; q_err[qt] = (errk >= 0);
      qt++;
    end
  endtask

  task automatic write_slot(input int s);
    logic [31:0] v;
    wr(8'(8'h20 + 4 * s), s_base[s]);
    wr(8'(8'h10 + 4 * s), s_word[s]);
    rd(8'(8'h10 + 4 * s), v);
    chk(v == (s_word[s] & 32'h003F_1FFF), "R4 status after write", v, s_word[s] & 32'h003F_1FFF);
    rd(8'h60, v);
    chk(v[s] == 1'b0, "R4 summary bit cleared", v, 32'(0));
  endtask

  task automatic wait_done(input logic [3:0] m);
    logic [31:0] v;
    do rd(8'h60, v); while ((v[3:0] & m) != m);
  endtask

  task automatic check_slot(input int s);
    logic [31:0] v, e;
    e = exp_done(s_word[s], s_err[s]);
    rd(8'(8'h10 + 4 * s), v);
    chk(v == e, s_err[s] ? "R6 status after abort" : "R5 status after completion", v, e);
    rd(8'(8'h20 + 4 * s), v);
    chk(v == s_base[s], "R12 address readback", v, s_base[s]);
  endtask

  task automatic clear_int(input logic [31:0] expect_int);
    logic [31:0] v;
    rd(8'h3C, v);
    chk(v == expect_int, "R5 interrupt status", v, expect_int);
    wr(8'h3C, 32'h0000_000C);
    rd(8'h3C, v);
    chk(v == 0 && irq == 1'b0, "R7 interrupt cleared", {v[30:0], irq}, 32'(0));
  endtask

  task automatic batch(input int n, input int fixed_len);
    logic [3:0] m = '0;
    for (int j = 0; j < n; j++) begin
      int len;
      if (fixed_len >= 0) len = fixed_len;
      else len = (($urandom % 4) == 0) ? int'($urandom % 60) : 60 + int'($urandom % 140);
      prep(nxt, len, -1);
      write_slot(nxt);
      m[nxt] = 1'b1;
      nxt = (nxt + 1) % 4;
    end
    wait_done(m);
    for (int s = 0; s < 4; s++) if (m[s]) check_slot(s);
    clear_int(32'h0000_0004);
  endtask

  initial begin : watchdog
    #1_500_000;
    chk(0, "watchdog expired", 32'(qh), 32'(qt));
    summary_and_end();
  end

  initial begin : host
    logic [31:0] v;
    int busy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h10 + 4 * s), v);
      chk(v == 32'h0000_2000, "R1 reset status", v, 32'h0000_2000);
    end
    rd(8'h60, v);
    chk(v == 0, "R1 reset summary", v, 0);
    rd(8'h3C, v);
    chk(v == 0 && !irq && !tx_valid && !mem_req_valid, "R1 reset idle", v, 0);

    // directed lengths around the pad limit
    batch(1, 0);
    batch(1, 59);
    batch(1, 60);
    batch(1, 61);
    batch(4, 1);

    // R9: out-of-turn hand-over waits
    prep(nxt, 70, -1);
    prep((nxt + 1) % 4, 30, -1);
    write_slot((nxt + 1) % 4);
    busy = 0;
    repeat (30) begin
      @(negedge clk);
      if (tx_valid || mem_req_valid) busy++;
    end
    chk(busy == 0, "R9 early slot waits", 32'(busy), 0);
    write_slot(nxt);
    wait_done(4'((1 << nxt) | (1 << ((nxt + 1) % 4))));
    check_slot(nxt);
    check_slot((nxt + 1) % 4);
    chk(qh == qt, "R9 both frames sent in order", 32'(qh), 32'(qt));
    clear_int(32'h0000_0004);
    nxt = (nxt + 2) % 4;

    // R8 and R12: rewrite a busy slot mid-frame
    prep(nxt, 180, -1);
    write_slot(nxt);
    wr(8'(8'h20 + 4 * nxt), 32'h00AB_C000);
    wr(8'(8'h10 + 4 * nxt), 32'h0000_0010);
    rd(8'(8'h10 + 4 * nxt), v);
    chk(v == (s_word[nxt] & 32'h003F_1FFF), "R8 busy write ignored", v, s_word[nxt] & 32'h003F_1FFF);
    wait_done(4'(1 << nxt));
    rd(8'(8'h10 + 4 * nxt), v);
    chk(v == exp_done(s_word[nxt], 0), "R8 status of original frame", v, exp_done(s_word[nxt], 0));
    rd(8'(8'h20 + 4 * nxt), v);
    chk(v == 32'h00AB_C000, "R12 address rewrite stored", v, 32'h00AB_C000);
    repeat (20) @(negedge clk);
    chk(qh == qt, "R8 no extra frame", 32'(qh), 32'(qt));
    clear_int(32'h0000_0004);
    nxt = (nxt + 1) % 4;

    // R6 / R7: error response, then separate clearing of the two flags
    prep(nxt, 120, -1);
    write_slot(nxt);
    wait_done(4'(1 << nxt));
    check_slot(nxt);
    nxt = (nxt + 1) % 4;
    prep(nxt, 150, 37);
    write_slot(nxt);
    wait_done(4'(1 << nxt));
    check_slot(nxt);
    err_addr = 32'hFFFF_FFFF;
    rd(8'h3C, v);
    chk(v == 32'h0000_000C && irq, "R6 both interrupt flags", v, 32'h0000_000C);
    wr(8'h3C, 32'h0000_0004);
    rd(8'h3C, v);
    chk(v == 32'h0000_0008 && irq, "R7 clear ok keeps err", v, 32'h0000_0008);
    wr(8'h3C, 32'h0000_0008);
    rd(8'h3C, v);
    chk(v == 0 && !irq, "R7 clear err", v, 0);
    nxt = (nxt + 1) % 4;

    // random batches
    for (int b = 0; b < 14; b++) batch(1 + int'($urandom % 4), -1);

    repeat (10) @(negedge clk);
    chk(qh == qt, "R2 all frames drained", 32'(qh), 32'(qt));
    chk(r10_viol == 0, "R10 fetch while offering", 32'(r10_viol), 0);
    chk(r11_viol == 0, "R11 tx stable under stall", 32'(r11_viol), 0);
    summary_and_end();
  end

  initial seed_dummy = $urandom(32'd20240611);
endmodule